// File: doc/BRIEF.md
# Compressed-instruction fetch aligner

This block sits between a 32-bit instruction fetch port and the decoder of a core that mixes 16-bit compressed and 32-bit instructions. Each fetch word arrives with the program counter of the instruction it carries. The PC's half-word select bit shows whether that instruction starts in the low half or the high half of the word. The block pulls one complete instruction out of the word and reports whether it is compressed. It also presents the instruction's own address and the next sequential PC.

A 32-bit instruction that starts in the upper half of a word spills into the next word. The block keeps that first half in a holding register and raises a pending indication. It then joins the half with the low half of the following fetch word. A valid/ready pair guards each side. New fetch words are refused while a finished instruction is still waiting for the decoder. With the ready-forwarding option, a word is accepted in the same cycle that the decoder takes the previous result.

Top module: `cfa_aligner`

## Requirements
- R1: After reset, out_valid and half_pending are 0, fetch_ready is 1 and out_insn is all zeros.
- R2: When fetch_pc bit 1 is 0 and fetch_word[1:0] is not 2'b11, the next cycle presents out_insn = {16'h0, fetch_word[15:0]} with out_valid set.
- R3: When fetch_pc bit 1 is 0 and fetch_word[1:0] is 2'b11, the next cycle presents the whole fetch_word as out_insn.
- R4: When fetch_pc bit 1 is 1, no half is pending, and fetch_word[17:16] is not 2'b11, the next cycle presents out_insn = {16'h0, fetch_word[31:16]}.
- R5: When fetch_pc bit 1 is 1, no half is pending, and fetch_word[17:16] is 2'b11, no instruction is presented; half_pending rises instead. The next accepted word completes the instruction as {next_word[15:0], held half}, and out_pc stays at the address of the first half.
- R6: out_compressed is 1 exactly when out_insn[1:0] is not 2'b11. Both 2'b00 and 2'b10 count as compressed.
- R7: While out_valid is set, out_next_pc equals out_pc + 2 for a compressed instruction and out_pc + 4 otherwise.
- R8: While out_valid is 1 and out_ready is 0, fetch_ready is 0 and out_insn, out_pc and out_valid hold their values.
- R9: While half_pending is 1, out_insn[31:16] is zero and out_valid is 0.
- R10: With the default ready-forwarding option, fetch_ready is 1 in any cycle where out_valid and out_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch word and PC are valid |
| fetch_ready | output | 1 | Aligner accepts a fetch word this cycle |
| fetch_word | input | 32 | Fetched instruction word |
| fetch_pc | input | PC_W | Address of the instruction carried by the word |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | Decoder takes the presented instruction |
| out_insn | output | 32 | Extracted instruction, zero-extended when compressed |
| out_compressed | output | 1 | Presented instruction is 16-bit |
| out_pc | output | PC_W | Address of the presented instruction |
| out_next_pc | output | PC_W | Sequential successor address |
| half_pending | output | 1 | First half of a split 32-bit instruction is held |

## Verification
Directed words cover each case on its own. A compressed and a full instruction in the low half show that the length test uses the right bits. A compressed and a full instruction in the high half show that the half select comes from the PC. A split instruction shows that the halves are joined in the right order and that out_pc keeps the first address. Low-bit codes 00, 01 and 10 tell a plain "bit 0 set" test apart from the true two-bit rule. A long random stream then walks the PC through each successor, so aligned, unaligned and split cases mix in every order. The decoder's ready line is held low, toggled and forced high, which separates correct stalling from dropped or duplicated instructions.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
   localparam int CFA_HALF_W = 16;

   // a parcel is 16-bit when its two lowest bits are not both set
   function automatic logic cfa_is_short(input logic [1:0] low_bits);
      return (low_bits != 2'b11);
   endfunction
endpackage

// File: rtl/cfa_halfsel.sv
module cfa_halfsel
   import cfa_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic [INSN_W-1:0]   word_i,
   input  logic                upper_sel_i,
   input  logic                mid_i,
   input  logic [INSN_W/2-1:0] held_lo_i,
   output logic [INSN_W-1:0]   held_n_o,
   output logic                mid_n_o,
   output logic                done_n_o
);
   localparam int HW = INSN_W / 2;

   logic [HW-1:0] lo_half;
   logic [HW-1:0] hi_half;

   assign lo_half = word_i[HW-1:0];
   assign hi_half = word_i[INSN_W-1:HW];

   always_comb begin
      held_n_o = '0;
      mid_n_o  = 1'b0;
      done_n_o = 1'b1;
      if (mid_i) begin
         held_n_o = {lo_half, held_lo_i};
      end else if (!upper_sel_i) begin
         if (cfa_is_short(lo_half[1:0])) held_n_o = {{HW{1'b0}}, lo_half};
         else                            held_n_o = word_i;
      end else begin
         held_n_o = {{HW{1'b0}}, hi_half};
         if (!cfa_is_short(hi_half[1:0])) begin
            mid_n_o  = 1'b1;
            done_n_o = 1'b0;
         end
      end
   end
endmodule

// File: rtl/cfa_pcgen.sv
module cfa_pcgen #(
   parameter int PC_W   = 32,
   parameter int INSN_W = 32
) (
   input  logic [PC_W-1:0] pc_i,
   input  logic            short_i,
   output logic [PC_W-1:0] next_pc_o
);
   localparam int SHORT_BYTES = INSN_W / 16;
   localparam int FULL_BYTES  = INSN_W / 8;

   assign next_pc_o = pc_i + (short_i ? PC_W'(SHORT_BYTES) : PC_W'(FULL_BYTES));
endmodule

// File: rtl/cfa_aligner.sv
module cfa_aligner
   import cfa_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int INSN_W    = 32,
   parameter bit READY_FWD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   output logic              fetch_ready,
   input  logic [INSN_W-1:0] fetch_word,
   input  logic [PC_W-1:0]   fetch_pc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [INSN_W-1:0] out_insn,
   output logic              out_compressed,
   output logic [PC_W-1:0]   out_pc,
   output logic [PC_W-1:0]   out_next_pc,
   output logic              half_pending
);
   localparam int HW       = INSN_W / 2;
   localparam int HSEL_BIT = $clog2(HW / 8);

   initial begin
      if (INSN_W != 2 * CFA_HALF_W)
         $fatal(1, "cfa_aligner: INSN_W must be twice the parcel width");
      if (PC_W <= HSEL_BIT + 1)
         $fatal(1, "cfa_aligner: PC_W too narrow");
   end

   logic [INSN_W-1:0] held_q, held_n;
   logic              mid_q, mid_n;
   logic              done_q, done_n;
   logic [PC_W-1:0]   pc_q;
   logic              accept;

   generate
      if (READY_FWD) begin : g_fwd
         assign fetch_ready = !done_q || out_ready;
      end else begin : g_plain
         assign fetch_ready = !done_q;
      end
   endgenerate

   assign accept = fetch_valid && fetch_ready;

   cfa_halfsel #(.INSN_W(INSN_W)) u_sel (
      .word_i      (fetch_word),
      .upper_sel_i (fetch_pc[HSEL_BIT]),
      .mid_i       (mid_q),
      .held_lo_i   (held_q[HW-1:0]),
      .held_n_o    (held_n),
      .mid_n_o     (mid_n),
      .done_n_o    (done_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
         mid_q  <= 1'b0;
         done_q <= 1'b0;
         pc_q   <= '0;
      end else if (accept) begin
         held_q <= held_n;
         mid_q  <= mid_n;
         done_q <= done_n;
         if (!mid_q) pc_q <= fetch_pc;
      end else if (done_q && out_ready) begin
         done_q <= 1'b0;
      end
   end

   assign out_valid      = done_q;
   assign out_insn       = held_q;
   assign out_pc         = pc_q;
   assign half_pending   = mid_q;
   assign out_compressed = cfa_is_short(held_q[1:0]);

   cfa_pcgen #(.PC_W(PC_W), .INSN_W(INSN_W)) u_pc (
      .pc_i      (pc_q),
      .short_i   (out_compressed),
      .next_pc_o (out_next_pc)
   );

   // R8: a stalled result stays put and blocks new fetch words
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_insn) && $stable(out_pc));
   a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !fetch_ready);
   // R9: a held first half has clean upper bits and nothing is presented
   a_r9_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      half_pending |-> (out_insn[INSN_W-1:HW] == '0) && !out_valid);
   // R5: a split instruction completes on the next accepted word
   a_r5_merge_done: assert property (@(posedge clk) disable iff (!rst_n)
      half_pending && accept |=> out_valid && !half_pending && $stable(out_pc));
   // R7: successor address follows the instruction length
   a_r7_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_next_pc == out_pc + (out_compressed ? PC_W'(2) : PC_W'(4)));
endmodule

// File: tb/cfa_aligner_test.sv
`timescale 1ns/1ps
module cfa_aligner_test;
   typedef struct packed {
      logic [31:0] insn;
      logic        comp;
      logic [31:0] pc;
      logic [31:0] npc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic        fetch_ready;
   logic [31:0] fetch_word = '0;
   logic [31:0] fetch_pc = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_insn;
   logic        out_compressed;
   logic [31:0] out_pc;
   logic [31:0] out_next_pc;
   logic        half_pending;

   int checks = 0;
   int errors = 0;
   int rdy_mode = 0;
   int cyc = 0;
   exp_t sb[$];
   logic        mid_m = 1'b0;
   logic [15:0] lo_m = '0;
   logic [31:0] ppc_m = '0;
   logic [31:0] nxt_pc = '0;

   always #2 clk = ~clk;

   cfa_aligner uut (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
      .fetch_word(fetch_word), .fetch_pc(fetch_pc), .out_valid(out_valid),
      .out_ready(out_ready), .out_insn(out_insn), .out_compressed(out_compressed),
      .out_pc(out_pc), .out_next_pc(out_next_pc), .half_pending(half_pending)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] insn, input logic [31:0] pc);
      exp_t e;
      e.insn = insn;
      e.comp = (insn[1:0] != 2'b11);
      e.pc   = pc;
      e.npc  = pc + (e.comp ? 32'd2 : 32'd4);
      sb.push_back(e);
      nxt_pc = e.npc;
   endtask

   // model of R2..R5, then drive the word through the handshake
   task automatic send(input logic [31:0] w, input logic [31:0] pc);
      if (mid_m) begin
         push({w[15:0], lo_m}, ppc_m);
         mid_m = 1'b0;
      end else if (!pc[1]) begin
         if (w[1:0] != 2'b11) push({16'h0, w[15:0]}, pc);
         else                 push(w, pc);
      end else if (w[17:16] != 2'b11) begin
         push({16'h0, w[31:16]}, pc);
      end else begin
         mid_m = 1'b1; lo_m = w[31:16]; ppc_m = pc; nxt_pc = pc + 32'd2;
      end
      @(negedge clk);
      fetch_valid = 1'b1; fetch_word = w; fetch_pc = pc;
      #1;
      while (!fetch_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      fetch_valid = 1'b0;
   endtask

   // monitor: sets the decoder's ready, then pops and compares on a handshake
   always @(negedge clk) begin
      cyc++;
      case (rdy_mode)
         0: out_ready = 1'b1;
         1: out_ready = cyc[0] ^ cyc[2];
         default: out_ready = 1'b0;
      endcase
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R2-R5 unexpected output", out_insn, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(out_insn == e.insn, "R2/R3/R4/R5 insn", out_insn, e.insn);
            chk(out_compressed == e.comp, "R6 compressed", {31'h0, out_compressed}, {31'h0, e.comp});
            chk(out_pc == e.pc, "R5 pc", out_pc, e.pc);
            chk(out_next_pc == e.npc, "R7 next pc", out_next_pc, e.npc);
         end
      end
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      summary();
   end

   initial begin
      logic [31:0] held;
      logic [31:0] cur;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      // R1
      chk(!out_valid, "R1 out_valid", {31'h0, out_valid}, 32'h0);
      chk(fetch_ready, "R1 fetch_ready", {31'h0, fetch_ready}, 32'h1);
      chk(!half_pending, "R1 half_pending", {31'h0, half_pending}, 32'h0);
      chk(out_insn == 32'h0, "R1 out_insn", out_insn, 32'h0);

      // R2, R3, R4, R6 directed
      send(32'hABCD_1235, 32'h100);           // R2 code 01
      send(32'h0041_0513, 32'h102 + 32'h0);   // R4-side pc bit 1 set
      send(32'h0041_0513, 32'h104);           // R3 full
      send(32'h4581_FFFF, 32'h10A);           // R4 upper 01
      send(32'h5555_0002, 32'h10C);           // R6 code 10
      send(32'h0000_7770, 32'h110);           // R6 code 00

      // R10: forwarded ready while a result is taken
      send(32'h1111_2221, 32'h120);
      @(negedge clk); #2;
      chk(out_valid && out_ready ? fetch_ready : 1'b1, "R10 forwarded ready", {31'h0, fetch_ready}, 32'h1);

      // R5, R9: split instruction
      send(32'h0513_BEEF, 32'h206);
      chk(half_pending, "R5 pending", {31'h0, half_pending}, 32'h1);
      chk(!out_valid, "R9 no output", {31'h0, out_valid}, 32'h0);
      chk(out_insn == 32'h0000_0513, "R9 upper clear", out_insn, 32'h0000_0513);
      send(32'h9999_0041, 32'h208);

      // R8: decoder stalls
      while (sb.size() != 0) @(negedge clk);
      rdy_mode = 2;
      send(32'h0000_00B3, 32'h300);
      @(negedge clk); #2;
      held = out_insn;
      repeat (3) @(negedge clk);
      #2;
      chk(out_valid, "R8 valid held", {31'h0, out_valid}, 32'h1);
      chk(!fetch_ready, "R8 fetch stalled", {31'h0, fetch_ready}, 32'h0);
      chk(out_insn == held, "R8 insn stable", out_insn, held);
      chk(out_insn == 32'h0000_00B3, "R8 insn value", out_insn, 32'h0000_00B3);
      rdy_mode = 0;

      // mixed random stream with toggling decoder ready
      rdy_mode = 1;
      cur = 32'h1000;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] w;
         w = $urandom;
         if (i % 5 == 0) w[17:16] = 2'b11;
         if (i % 7 == 0) w[1:0] = 2'b11;
         send(w, cur);
         cur = nxt_pc;
      end
      if (mid_m) send(32'h0000_0001, cur);
      rdy_mode = 0;
      while (sb.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      summary();
   end
endmodule